// File: doc/BRIEF.md
# Parity Bus Transceiver with Check

This block is an eight-bit bidirectional bus transceiver that carries a ninth parity bit alongside the data byte. A direction input chooses which side drives. When it is high, data flows from the A side to the B side. When it is low, data flows from the B side to the A side. An active-low enable gates every output. A sense input chooses odd or even parity for both generation and checking.

When the block transmits toward B, it computes a parity bit from the A byte and drives it on the parity pin together with the byte. The check always watches the nine bits present on the B-side bus, which are the B byte plus the parity pin. In receive mode this checks incoming words. In transmit mode the driven word loops back through the pins, so a fault on the bus shows up on the same flag.

Each tri-state pin is modelled as three signals: an input, an output and an output enable. The block has no clock, so every output follows its inputs combinationally.

Top module: `parity_xcvr`

## Requirements
- R1: With `oe_n` low and `tx` high, `b_oe` is 1, `a_oe` is 0 and `b_out` equals `a_in`.
- R2: With `oe_n` low and `tx` low, `a_oe` is 1, `b_oe` is 0 and `a_out` equals `b_in`.
- R3: `par_oe` is 1 exactly when `oe_n` is low and `tx` is high. The parity pin is an input in every other state.
- R4: While `par_oe` is 1, the count of ones in {`b_out`, `par_out`} is odd when `odd_sel` is 1 and even when `odd_sel` is 0.
- R5: With `oe_n` high, `a_oe`, `b_oe`, `par_oe` and `err` are all 0, whatever the other inputs are.
- R6: With `oe_n` low, in either direction, `err` is 1 exactly when the count of ones in {`b_in`, `par_in`} is even while `odd_sel` is 1, or odd while `odd_sel` is 0.
- R7: Any data or parity output whose enable is 0 presents the value 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oe_n | input | 1 | Active-low enable for all outputs and for the error flag |
| tx | input | 1 | 1: A drives B and parity is generated; 0: B drives A |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| a_in | input | WIDTH | Value sensed on the A-side pins |
| a_out | output | WIDTH | Value driven onto the A-side pins |
| a_oe | output | 1 | A-side pin drive enable |
| b_in | input | WIDTH | Value sensed on the B-side pins |
| b_out | output | WIDTH | Value driven onto the B-side pins |
| b_oe | output | 1 | B-side pin drive enable |
| par_in | input | 1 | Value sensed on the parity pin |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Parity pin drive enable |
| err | output | 1 | Parity check failure on the B-side nine-bit word |

## Verification
The block holds no state, so a wrong internal value cannot hide. It shows at the ports in the same evaluation as the input that exposes it. A wrong polarity in the generator appears as a driven nine-bit word of the wrong sense for every byte. A wrong polarity in the checker raises the flag on every clean looped-back word. A bad enable decode shows up as both sides driving at once, or as pins driven while the block is disabled. The vectors cover every combination of direction, enable and sense against a bit-counting model, which catches any of these faults on the first vector that selects the faulty path.

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
  parameter int WIDTH = 8
) (
  input  logic             oe_n,
  input  logic             tx,
  input  logic             odd_sel,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             par_in,
  output logic             par_out,
  output logic             par_oe,
  output logic             err
);

  logic en;

  assign en      = ~oe_n;
  assign b_oe    = en & tx;
  assign a_oe    = en & ~tx;
  assign par_oe  = en & tx;
  assign b_out   = b_oe ? a_in : '0;
  assign a_out   = a_oe ? b_in : '0;
  assign par_out = par_oe & ((^a_in) ^ odd_sel);
  assign err     = en & ((^{b_in, par_in}) ^ odd_sel);

  always_comb begin
    if (oe_n) begin
      p_quiet_when_off_r5: assert (!a_oe && !b_oe && !par_oe && !err);
    end
    p_single_driver_r2: assert (!(a_oe && b_oe));
    if (b_oe) begin
      p_a_to_b_r1: assert (b_out == a_in);
    end
    if (a_oe) begin
      p_b_to_a_r2: assert (a_out == b_in);
    end
    if (par_oe) begin
      p_parity_with_b_r3: assert (b_oe);
      p_gen_sense_r4: assert ((($countones({b_out, par_out}) % 2) == 1) == odd_sel);
    end
    if (err) begin
      p_err_only_bad_word_r6: assert (!oe_n && ((($countones({b_in, par_in}) % 2) == 1) != odd_sel));
    end
    if (!b_oe) begin
      p_idle_b_zero_r7: assert (b_out == '0 && par_out == 1'b0);
    end
  end

endmodule

// File: tb/test_parity_xcvr.sv
module test_parity_xcvr;
  localparam int W = 8;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         oe_n, tx, odd_sel, par_in;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe, par_out, par_oe, err;

  int n_run = 0;
  int n_fail = 0;

  parity_xcvr #(.WIDTH(W)) i_parity_xcvr (
    .oe_n(oe_n), .tx(tx), .odd_sel(odd_sel),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
    .err(err)
  );

  // {oe_n, tx, odd_sel, a_in, b_in, par_in}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0},
    {1'b0, 1'b1, 1'b0, 8'h00, 8'h5A, 1'b1},
    {1'b0, 1'b1, 1'b1, 8'hA7, 8'h13, 1'b0},
    {1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b0},
    {1'b0, 1'b0, 1'b1, 8'h3C, 8'h01, 1'b0},
    {1'b0, 1'b0, 1'b1, 8'h3C, 8'h01, 1'b1},
    {1'b0, 1'b0, 1'b0, 8'h81, 8'h80, 1'b0},
    {1'b0, 1'b0, 1'b0, 8'h81, 8'hC0, 1'b0},
    {1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h55, 8'h01, 1'b0},
    {1'b0, 1'b1, 1'b1, 8'h7F, 8'h00, 1'b0},
    {1'b0, 1'b0, 1'b1, 8'hFE, 8'hFE, 1'b0}
  };

  function automatic int ones(input logic [W:0] v);
    int c = 0;
    for (int i = 0; i <= W; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (oe_n=%0b tx=%0b odd=%0b a=%0h b=%0h p=%0b)",
               req, act, exp, oe_n, tx, odd_sel, a_in, b_in, par_in);
    end
  endtask

  task automatic apply(input logic [19:0] v);
    @(posedge clk);
    #5;
    {oe_n, tx, odd_sel, a_in, b_in, par_in} = v;
    #5;
  endtask

  task automatic check_all();
    logic en, e_boe, e_aoe, e_par, e_err;
    en    = !oe_n;
    e_boe = en && tx;
    e_aoe = en && !tx;
    e_par = e_boe && ((ones({1'b0, a_in}) % 2 == 0) == odd_sel);
    e_err = en && (((ones({b_in, par_in}) % 2) == 1) != odd_sel);
    check("R1 b side enable/data", {b_oe, 23'd0, b_out}, {e_boe, 23'd0, (e_boe ? a_in : 8'h00)});
    check("R2 a side enable/data", {a_oe, 23'd0, a_out}, {e_aoe, 23'd0, (e_aoe ? b_in : 8'h00)});
    check("R3 parity pin enable", 32'(par_oe), 32'(e_boe));
    check("R4 generated parity", 32'(par_out), 32'(e_par));
    check("R6 error flag", 32'(err), 32'(e_err));
    if (!en) check("R5 all quiet", {28'd0, a_oe, b_oe, par_oe, err}, 32'd0);
    if (!e_boe) check("R7 idle outputs zero", {23'd0, par_out, b_out}, 32'd0);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    oe_n = 1'b1; tx = 1'b0; odd_sel = 1'b0; a_in = '0; b_in = '0; par_in = 1'b0;
    repeat (2) @(posedge clk);
    #5;
    rst_n = 1'b1;
    check("R5 start quiet", {28'd0, a_oe, b_oe, par_oe, err}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k]);
      check_all();
    end

    for (int c = 0; c < 8; c++) begin
      for (int d = 0; d < 16; d++) begin
        logic [7:0] byte_v;
        byte_v = 8'(d * 37 + c * 11);
        apply({c[2], c[1], c[0], byte_v, ~byte_v, d[0]});
        check_all();
      end
    end

    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 8; d++) begin
        logic [7:0] byte_v;
        byte_v = 8'(1 << d) ^ 8'(d);
        apply({1'b0, 1'b1, s[0], byte_v, 8'h00, 1'b0});
        b_in = b_out;
        par_in = par_out;
        #1;
        check("R6 loopback clean R4", 32'(err), 32'd0);
        b_in[0] = ~b_in[0];
        #1;
        check("R6 loopback flipped bit", 32'(err), 32'd1);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule